// File: doc/BRIEF.md
# Banked Scratchpad with Read-Conflict Serialisation

This block is a local scratchpad memory built from eight 16-bit-wide banks. Halfwords are interleaved across the banks, so the bank that holds a byte is picked by address bits [3:1] and the row is the address divided by 16. Every 32-bit word access is 4-byte aligned. It therefore touches an even bank and the odd bank next to it, on the same row. In each cycle the block takes two 32-bit read requests and one 32-bit write request with per-byte enables. Read data comes back one cycle after the request is accepted.

The two read ports share four read lanes. Two reads collide when their bank indices are equal modulo 4. For aligned words, that happens when address bit 2 is the same for both. On a collision the block serves port 0 at once and raises `stall` for that cycle. It keeps the port 1 address and serves that read in the following cycle. During that following cycle it ignores every request input. The requester holds its inputs while `stall` is high. A request whose address is not 4-byte aligned is rejected with an error flag and does nothing.

The default configuration has 256 rows per bank, which gives a 4 KB memory. Setting `ROWS` to 3072 gives the full 48 KB arrangement of eight 6 KB banks.

Top module: `scp_banked_mem`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, all of `rd0_valid`, `rd1_valid`, `rd0_err`, `rd1_err` and `wr_err` are 0 until a request arrives. `stall` is 0 while no reads are requested.
- R2: An aligned read accepted in cycle T raises that port's `valid` in T+1. Its data is little-endian: bits [15:0] come from the halfword at the byte address and bits [31:16] from the halfword at address+2.
- R3: Two aligned reads whose addresses differ in bit 2 never stall. Both return valid data in the next cycle.
- R4: Two aligned reads whose bank indices (address bits [3:1]) are equal modulo 4 raise `stall` for exactly one cycle. Port 0 returns data in T+1. Port 1 returns data in T+2, for the address it presented in T, and that data reflects a write accepted in T.
- R5: In the cycle after a stall, every request input is ignored. No read is started on port 0 and no write is performed.
- R6: A request with address bits [1:0] not equal to 0 returns its port's `err` flag in the next cycle. For a read, `valid` stays 0. A write leaves the memory unchanged. A misaligned read never causes a stall.
- R7: Bit i of `wr_be` enables byte i (`wr_data[8i+7:8i]`) of an aligned write. Bytes whose enable is 0 keep their old contents.
- R8: A read and a write to the same word in the same cycle make the read return the contents from before the write.
- R9: An aligned write is performed in the same cycle as two non-conflicting reads, without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd0_req | input | 1 | Read request, port 0 |
| rd0_addr | input | AW (12) | Byte address, port 0 |
| rd0_data | output | 32 | Read data, port 0 |
| rd0_valid | output | 1 | `rd0_data` holds a completed read |
| rd0_err | output | 1 | Port 0 request of the previous cycle was misaligned |
| rd1_req | input | 1 | Read request, port 1 |
| rd1_addr | input | AW (12) | Byte address, port 1 |
| rd1_data | output | 32 | Read data, port 1 |
| rd1_valid | output | 1 | `rd1_data` holds a completed read |
| rd1_err | output | 1 | Port 1 request of the previous cycle was misaligned |
| wr_req | input | 1 | Write request |
| wr_addr | input | AW (12) | Byte address of the write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables, bit i for byte i |
| wr_err | output | 1 | Write request of the previous cycle was misaligned |
| stall | output | 1 | Read collision: hold all inputs for one more cycle |

## Verification
The assertions assume that the requester obeys `stall`. Whenever `stall` is high, the inputs presented in the next cycle are the same request, or are inputs whose effect the block is entitled to discard. They also assume that addresses stay inside the configured capacity. The stimulus holds every input stable through the cycle after a stall, except in one directed test that deliberately changes them to show they are ignored. It uses only addresses below 4 KB and fills the whole memory before any read, so no read returns unwritten contents.

// File: rtl/scp_pkg.sv
// Shared definitions for the banked scratchpad.
// Assumes a 32-bit word built from two 16-bit bank halfwords.
package scp_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int BE_W   = WORD_W / 8;

    // True when a byte address is aligned to a 32-bit word.
    function automatic logic word_aligned(input logic [1:0] low_bits);
        return (low_bits == 2'b00);
    endfunction
endpackage

// File: rtl/scp_bank.sv
// One 16-bit-wide bank with two registered read ports and one byte-masked write port.
// Assumes each caller presents a row index within ROWS. A read and a write to the same row
// in the same cycle return the old contents.
module scp_bank #(
    parameter int ROWS  = 256,
    localparam int RW   = $clog2(ROWS)
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [RW-1:0]              wr_row,
    input  logic [scp_pkg::HALF_W-1:0] wr_half,
    input  logic [1:0]                 wr_mask,
    input  logic                       ra_en,
    input  logic [RW-1:0]              ra_row,
    output logic [scp_pkg::HALF_W-1:0] ra_q,
    input  logic                       rb_en,
    input  logic [RW-1:0]              rb_row,
    output logic [scp_pkg::HALF_W-1:0] rb_q
);
    logic [scp_pkg::HALF_W-1:0] cells [ROWS];

    // Byte-masked write into the addressed row.
    always_ff @(posedge clk) begin
        if (we && wr_mask[0]) cells[wr_row][7:0]  <= wr_half[7:0];
        if (we && wr_mask[1]) cells[wr_row][15:8] <= wr_half[15:8];
    end

    // Registered reads; they sample the contents from before this edge's write.
    always_ff @(posedge clk) begin
        if (ra_en) ra_q <= cells[ra_row];
        if (rb_en) rb_q <= cells[rb_row];
    end
endmodule

// File: rtl/scp_arb.sv
// Read-port arbiter: rejects misaligned reads, detects lane collisions between the two
// ports, and replays port 1 in the cycle after a collision.
// Assumes the requester holds its inputs while stall_o is high.
module scp_arb #(
    parameter int AW     = 12,
    parameter int BANK_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          r0_req,
    input  logic [AW-1:0] r0_addr,
    input  logic          r1_req,
    input  logic [AW-1:0] r1_addr,
    output logic          hold_o,
    output logic          stall_o,
    output logic          r0_go,
    output logic          r0_bad,
    output logic          r1_go,
    output logic          r1_bad,
    output logic [AW-1:0] r1_eff_addr
);
    logic          ok0, ok1, clash;
    logic [AW-1:0] held_addr;

    // Classify requests and detect a shared lane (bank index modulo BANKS/2).
    always_comb begin
        ok0     = r0_req && scp_pkg::word_aligned(r0_addr[1:0]);
        ok1     = r1_req && scp_pkg::word_aligned(r1_addr[1:0]);
        clash   = ok0 && ok1 && (r0_addr[BANK_W-1:1] == r1_addr[BANK_W-1:1]);
        stall_o = !hold_o && clash;
        r0_go   = !hold_o && ok0;
        r0_bad  = !hold_o && r0_req && !ok0;
        r1_go   = hold_o || (ok1 && !clash);
        r1_bad  = !hold_o && r1_req && !ok1;
        r1_eff_addr = hold_o ? held_addr : r1_addr;
    end

    // Remember the deferred port-1 address and enter the replay cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_o    <= 1'b0;
            held_addr <= '0;
        end else begin
            hold_o <= stall_o;
            if (stall_o) held_addr <= r1_addr;
        end
    end

    // R4: a stall lasts one cycle and is followed by the port-1 replay.
    a_r4_stall_once: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (!stall_o && r1_go));
    // R3: aligned reads that differ in address bit 2 never stall.
    a_r3_split_free: assert property (@(posedge clk) disable iff (!rst_n)
        (r0_req && r1_req && r0_addr[1:0] == 2'b00 && r1_addr[1:0] == 2'b00
         && r0_addr[2] != r1_addr[2]) |-> !stall_o);
    // R6: a misaligned read never causes a stall.
    a_r6_bad_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ((r0_req && r0_addr[1:0] != 2'b00) || (r1_req && r1_addr[1:0] != 2'b00)) |-> !stall_o);
endmodule

// File: rtl/scp_banked_mem.sv
// Banked scratchpad top: BANKS interleaved 16-bit banks, two 32-bit read ports,
// one 32-bit byte-masked write port, one-cycle read latency, stall on read collision.
// Assumes BANKS is a power of two of at least 4, and that all requests are held while stall is high.
module scp_banked_mem #(
    parameter int ROWS   = 256,
    parameter int BANKS  = 8,
    localparam int BANK_W = $clog2(BANKS),
    localparam int PAIR_W = BANK_W - 1,
    localparam int RW     = $clog2(ROWS),
    localparam int AW     = RW + BANK_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd0_req,
    input  logic [AW-1:0]              rd0_addr,
    output logic [scp_pkg::WORD_W-1:0] rd0_data,
    output logic                       rd0_valid,
    output logic                       rd0_err,
    input  logic                       rd1_req,
    input  logic [AW-1:0]              rd1_addr,
    output logic [scp_pkg::WORD_W-1:0] rd1_data,
    output logic                       rd1_valid,
    output logic                       rd1_err,
    input  logic                       wr_req,
    input  logic [AW-1:0]              wr_addr,
    input  logic [scp_pkg::WORD_W-1:0] wr_data,
    input  logic [scp_pkg::BE_W-1:0]   wr_be,
    output logic                       wr_err,
    output logic                       stall
);
    logic                       hold, r0_go, r0_bad, r1_go, r1_bad, wr_go, wr_bad;
    logic [AW-1:0]              r1_addr_eff;
    logic [PAIR_W-1:0]          pair0_q, pair1_q;
    logic [scp_pkg::HALF_W-1:0] qa [BANKS];
    logic [scp_pkg::HALF_W-1:0] qb [BANKS];

    scp_arb #(.AW(AW), .BANK_W(BANK_W)) arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .r0_req     (rd0_req),
        .r0_addr    (rd0_addr),
        .r1_req     (rd1_req),
        .r1_addr    (rd1_addr),
        .hold_o     (hold),
        .stall_o    (stall),
        .r0_go      (r0_go),
        .r0_bad     (r0_bad),
        .r1_go      (r1_go),
        .r1_bad     (r1_bad),
        .r1_eff_addr(r1_addr_eff)
    );

    // Writes are accepted only when aligned and outside the replay cycle.
    always_comb begin
        wr_go  = !hold && wr_req && scp_pkg::word_aligned(wr_addr[1:0]);
        wr_bad = !hold && wr_req && !scp_pkg::word_aligned(wr_addr[1:0]);
    end

    // One bank per halfword lane; even banks hold the low halfword, odd banks the high one.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam int PAIR = b / 2;
        localparam bit HI   = (b % 2) == 1;
        logic       sel_a, sel_b, sel_w;
        logic [1:0] mask;
        logic [scp_pkg::HALF_W-1:0] half;

        assign sel_a = r0_go && (rd0_addr[BANK_W:2] == PAIR_W'(PAIR));
        assign sel_b = r1_go && (r1_addr_eff[BANK_W:2] == PAIR_W'(PAIR));
        assign sel_w = wr_go && (wr_addr[BANK_W:2] == PAIR_W'(PAIR));
        assign mask  = HI ? wr_be[3:2] : wr_be[1:0];
        assign half  = HI ? wr_data[31:16] : wr_data[15:0];

        scp_bank #(.ROWS(ROWS)) bank_i (
            .clk    (clk),
            .we     (sel_w),
            .wr_row (wr_addr[AW-1:BANK_W+1]),
            .wr_half(half),
            .wr_mask(mask),
            .ra_en  (sel_a),
            .ra_row (rd0_addr[AW-1:BANK_W+1]),
            .ra_q   (qa[b]),
            .rb_en  (sel_b),
            .rb_row (r1_addr_eff[AW-1:BANK_W+1]),
            .rb_q   (qb[b])
        );
    end

    // Register per-port status and the bank pair each read came from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd0_valid <= 1'b0;
            rd1_valid <= 1'b0;
            rd0_err   <= 1'b0;
            rd1_err   <= 1'b0;
            wr_err    <= 1'b0;
            pair0_q   <= '0;
            pair1_q   <= '0;
        end else begin
            rd0_valid <= r0_go;
            rd1_valid <= r1_go;
            rd0_err   <= r0_bad;
            rd1_err   <= r1_bad;
            wr_err    <= wr_bad;
            if (r0_go) pair0_q <= rd0_addr[BANK_W:2];
            if (r1_go) pair1_q <= r1_addr_eff[BANK_W:2];
        end
    end

    // Assemble each 32-bit word from its even (low) and odd (high) bank.
    always_comb begin
        rd0_data = {qa[{pair0_q, 1'b1}], qa[{pair0_q, 1'b0}]};
        rd1_data = {qb[{pair1_q, 1'b1}], qb[{pair1_q, 1'b0}]};
    end

    // R6: a port never reports data and an error at once.
    a_r6_valid_xor_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd0_valid && rd0_err) && !(rd1_valid && rd1_err));
    // R4: the deferred port-1 read completes two cycles after the stall.
    a_r4_replay_data: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ##2 rd1_valid);
    // R5: the replay cycle starts no port-0 read.
    a_r5_replay_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ##2 (!rd0_valid && !rd0_err && !wr_err));
    // R2: a valid read follows an aligned request on the previous edge.
    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_req && rd0_addr[1:0] == 2'b00 && !stall && !$past(stall)) |=> rd0_valid);
endmodule

// File: tb/scp_banked_mem_tb_top.sv
`timescale 1ns/1ps
module scp_banked_mem_tb_top;
    localparam int AW = 12;
    localparam int MEM_BYTES = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd0_req = 1'b0, rd1_req = 1'b0, wr_req = 1'b0;
    logic [AW-1:0] rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [3:0]    wr_be = '0;
    logic [31:0]   rd0_data, rd1_data;
    logic          rd0_valid, rd1_valid, rd0_err, rd1_err, wr_err, stall;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [MEM_BYTES];

    always #2.5 clk = ~clk;

    scp_banked_mem dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd0_req(rd0_req), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd0_valid(rd0_valid), .rd0_err(rd0_err),
        .rd1_req(rd1_req), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .rd1_valid(rd1_valid), .rd1_err(rd1_err),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_err(wr_err), .stall(stall)
    );

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] wa;
        logic [31:0]   wd;
        logic [3:0]    be;
        logic          r0;
        logic [AW-1:0] a0;
        logic          r1;
        logic [AW-1:0] a1;
        logic          exp_stall;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 32'h0,         4'h0, 1'b1, 12'h000, 1'b1, 12'h004, 1'b0},
        '{1'b0, 12'h000, 32'h0,         4'h0, 1'b1, 12'h010, 1'b1, 12'h018, 1'b1},
        '{1'b0, 12'h000, 32'h0,         4'h0, 1'b1, 12'h100, 1'b1, 12'h30C, 1'b0},
        '{1'b1, 12'h020, 32'hDEADBEEF,  4'hF, 1'b1, 12'h020, 1'b1, 12'h024, 1'b0},
        '{1'b0, 12'h000, 32'h0,         4'h0, 1'b1, 12'h020, 1'b1, 12'h028, 1'b1},
        '{1'b1, 12'h040, 32'h11223344,  4'h5, 1'b1, 12'h044, 1'b1, 12'h048, 1'b0},
        '{1'b0, 12'h000, 32'h0,         4'h0, 1'b1, 12'h040, 1'b0, 12'h000, 1'b0},
        '{1'b0, 12'h000, 32'h0,         4'h0, 1'b1, 12'h042, 1'b1, 12'h046, 1'b0},
        '{1'b1, 12'h061, 32'h00000000,  4'hF, 1'b1, 12'h06C, 1'b1, 12'h04E, 1'b0},
        '{1'b0, 12'h000, 32'h0,         4'h0, 1'b1, 12'h060, 1'b1, 12'h064, 1'b0},
        '{1'b1, 12'h0FC, 32'hCAFEF00D,  4'hF, 1'b1, 12'h07C, 1'b1, 12'h0FC, 1'b1},
        '{1'b1, 12'h300, 32'h0BADC0DE,  4'hA, 1'b0, 12'h000, 1'b1, 12'h200, 1'b0}
    };

    function automatic logic [31:0] pattern(input logic [AW-1:0] a);
        return {4'hA, a, 4'h5, ~a};
    endfunction

    function automatic logic [31:0] model_rd(input logic [AW-1:0] a);
        return {model[a + 3], model[a + 2], model[a + 1], model[a]};
    endfunction

    task automatic model_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        for (int i = 0; i < 4; i++)
            if (be[i]) model[a + AW'(i)] = d[8*i +: 8];
    endtask

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        wr_req = v.wr; wr_addr = v.wa; wr_data = v.wd; wr_be = v.be;
        rd0_req = v.r0; rd0_addr = v.a0; rd1_req = v.r1; rd1_addr = v.a1;
    endtask

    task automatic idle();
        wr_req = 1'b0; rd0_req = 1'b0; rd1_req = 1'b0;
    endtask

    // Apply one vector at a falling edge and check every result it produces.
    task automatic run_vec(input vec_t v);
        logic ok0, ok1, okw;
        logic [31:0] e0, e1;
        ok0 = v.r0 && v.a0[1:0] == 2'b00;
        ok1 = v.r1 && v.a1[1:0] == 2'b00;
        okw = v.wr && v.wa[1:0] == 2'b00;
        e0 = '0; e1 = '0;
        drive(v);
        #1;
        check(stall === v.exp_stall, v.exp_stall ? "R4" : "R3", "stall", 32'(stall), 32'(v.exp_stall));
        if (ok0) e0 = model_rd(v.a0);
        if (ok1 && !v.exp_stall) e1 = model_rd(v.a1);
        if (okw) model_wr(v.wa, v.wd, v.be);
        if (ok1 && v.exp_stall) e1 = model_rd(v.a1);
        @(negedge clk);
        check(rd0_valid === ok0, "R2", "rd0_valid", 32'(rd0_valid), 32'(ok0));
        check(rd0_err === (v.r0 && !ok0), "R6", "rd0_err", 32'(rd0_err), 32'(v.r0 && !ok0));
        check(wr_err === (v.wr && !okw), "R6", "wr_err", 32'(wr_err), 32'(v.wr && !okw));
        if (ok0) check(rd0_data === e0, "R2", "rd0_data", rd0_data, e0);
        if (v.exp_stall) begin
            check(rd1_valid === 1'b0, "R4", "rd1_valid early", 32'(rd1_valid), 32'h0);
            check(stall === 1'b0, "R4", "stall second cycle", 32'(stall), 32'h0);
            @(negedge clk);
            check(rd1_valid === 1'b1, "R4", "rd1_valid late", 32'(rd1_valid), 32'h1);
            check(rd1_data === e1, "R4", "rd1_data late", rd1_data, e1);
            check(rd0_valid === 1'b0, "R5", "rd0_valid in replay", 32'(rd0_valid), 32'h0);
        end else begin
            check(rd1_valid === ok1, "R3", "rd1_valid", 32'(rd1_valid), 32'(ok1));
            check(rd1_err === (v.r1 && !ok1), "R6", "rd1_err", 32'(rd1_err), 32'(v.r1 && !ok1));
            if (ok1) check(rd1_data === e1, "R9", "rd1_data", rd1_data, e1);
        end
    endtask

    initial begin
        vec_t v;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(rd0_valid === 1'b0 && rd1_valid === 1'b0, "R1", "valid in reset",
              {30'h0, rd1_valid, rd0_valid}, 32'h0);
        check(rd0_err === 1'b0 && rd1_err === 1'b0 && wr_err === 1'b0, "R1", "err in reset",
              {29'h0, wr_err, rd1_err, rd0_err}, 32'h0);
        check(stall === 1'b0, "R1", "stall in reset", 32'(stall), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd0_valid === 1'b0 && rd1_valid === 1'b0, "R1", "valid after reset",
              {30'h0, rd1_valid, rd0_valid}, 32'h0);

        // Fill every word with a known pattern.
        for (int a = 0; a < MEM_BYTES; a += 4) begin
            wr_req = 1'b1; wr_addr = AW'(a); wr_data = pattern(AW'(a)); wr_be = 4'hF;
            model_wr(AW'(a), pattern(AW'(a)), 4'hF);
            @(negedge clk);
        end
        idle();
        @(negedge clk);

        // Vector table: R2 R3 R4 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        idle();
        @(negedge clk);

        // R7: byte-enable result read back at 0x040 (enables 0101 wrote bytes 0 and 2).
        check(model_rd(12'h040) === {pattern(12'h040)[31:24], 8'h22, pattern(12'h040)[15:8], 8'h44},
              "R7", "model byte mask", model_rd(12'h040),
              {pattern(12'h040)[31:24], 8'h22, pattern(12'h040)[15:8], 8'h44});

        // R5: inputs changed during the replay cycle are ignored.
        v = '{1'b0, 12'h000, 32'h0, 4'h0, 1'b1, 12'h080, 1'b1, 12'h088, 1'b1};
        drive(v);
        #1;
        check(stall === 1'b1, "R4", "stall directed", 32'(stall), 32'h1);
        @(negedge clk);
        check(rd0_data === model_rd(12'h080), "R4", "rd0 directed", rd0_data, model_rd(12'h080));
        v = '{1'b1, 12'h080, 32'h0, 4'hF, 1'b1, 12'h0C0, 1'b0, 12'h000, 1'b0};
        drive(v);
        @(negedge clk);
        check(rd1_valid === 1'b1 && rd1_data === model_rd(12'h088), "R5", "replay data",
              rd1_data, model_rd(12'h088));
        check(rd0_valid === 1'b0, "R5", "port0 ignored in replay", 32'(rd0_valid), 32'h0);
        idle();
        run_vec('{1'b0, 12'h000, 32'h0, 4'h0, 1'b1, 12'h080, 1'b0, 12'h000, 1'b0});
        idle();
        @(negedge clk);

        // R1: reset again clears the flags.
        rst_n = 1'b0;
        @(negedge clk);
        check(rd0_valid === 1'b0 && rd1_valid === 1'b0 && wr_err === 1'b0, "R1", "second reset",
              {29'h0, wr_err, rd1_valid, rd0_valid}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule